// File: doc/BRIEF.md
# ALU Status Flag Register

This block is the 8-bit status register of a small 8-bit microcontroller core. It keeps three kinds of state in one byte:
- the arithmetic flags (zero, digit carry, carry);
- two reset-cause bits that record watchdog and sleep activity;
- three program page preselect bits, which the program counter logic reads when it performs a far jump.

The block brings together three sources of update. Software writes the register as an ordinary file register. The ALU reports an operation kind and its operands, and the block derives the flags that operation produces. The power and watchdog logic signals reset-cause events.

The rules for merging these sources are what make the block more than a plain register. When an instruction writes this register and also affects flags, the written data never reaches the flag bits. The reset-cause bits cannot be written by software at all. The decoder passes the ALU operation kind and its operands. The block decides which flags the operation touches and computes their new values.

Top module: `status_reg`

## Requirements
- R1: While `rst_n` is low, `stat_q` is 8'b000_1_1_000. Bits [7:5] (page) are 0, bit 4 (time-out) and bit 3 (power-down) are 1, and bits 2 (Z), 1 (DC) and 0 (C) are 0.
- R2: A write (`wr_en`=1) with an `alu_op` that touches no flag (0, 6 or 7) loads `wr_data` bits [7:5] and [2:0] into the register one cycle later.
- R3: A software write never changes bit 4 or bit 3.
- R4: If `alu_op` affects any flag, `wr_data` reaches none of bits [2:0], whether or not `wr_en` is high. Affected flags take the ALU result and unaffected flags keep their value. Bits [7:5] still follow the write. For example, clearing the register (write 0 with op 1 and `alu_a`=0) gives page 000 and Z=1, and leaves DC and C unchanged.
- R5: Op 1 (zero test) sets Z to 1 when `alu_a` is zero and to 0 otherwise. It affects only Z.
- R6: Op 2 (add `alu_a`+`alu_b`) sets C to the carry out of bit 7, DC to the carry out of bit 3, and Z when the 8-bit sum is zero.
- R7: Op 3 (subtract `alu_a`-`alu_b`) sets C to 1 when no borrow occurs out of bit 7 and DC to 1 when no borrow occurs out of bit 3. It sets Z when the difference is zero.
- R8: Op 4 (rotate right) loads C with `alu_a` bit 0. Op 5 (rotate left) loads C with `alu_a` bit 7. Both leave Z and DC unchanged.
- R9: `wdt_clr` or `sleep_cmd` sets time-out to 1. `wdt_tmo` clears it to 0, unless `wdt_clr` or `sleep_cmd` is asserted in the same cycle, in which case the set wins.
- R10: `wdt_clr` sets power-down to 1. `sleep_cmd` clears it to 0, unless `wdt_clr` is asserted in the same cycle, in which case the set wins.
- R11: With no write, no flag-affecting op and no event, every bit keeps its value.
- R12: `page_sel` always equals `stat_q[6:5]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| wr_en | input | 1 | Software write strobe for this register |
| wr_data | input | 8 | Software write data |
| alu_op | input | 3 | Flag-producing operation kind: 0 none, 1 zero test, 2 add, 3 subtract, 4 rotate right, 5 rotate left, 6 and 7 none |
| alu_a | input | W | First ALU operand; also the zero-test value and the rotate operand |
| alu_b | input | W | Second ALU operand |
| wdt_clr | input | 1 | Watchdog-clear instruction executed |
| sleep_cmd | input | 1 | Sleep instruction executed |
| wdt_tmo | input | 1 | Watchdog time-out occurred |
| stat_q | output | 8 | Register value for readback |
| page_sel | output | 2 | Page preselect bits passed to the program counter |

## Verification
The bench targets several corner cases:
- Writes that collide with flag-affecting operations. A design that lets data through to DC or C during a zero test would break the clear example.
- Carry edges at the nibble and byte boundaries, such as 0x0F+0x01 and 0xFF+0x01. A design that takes DC from the wrong bit, or that inverts the sense of borrow, fails these.
- Rotate operands with only the MSB or only the LSB set, which expose a swapped rotate direction.
- Simultaneous watchdog events, which expose a reversed priority between clear and time-out or between clear and sleep.

Random cycles mix all of these cases against a bench model of the requirements.

// File: rtl/status_pkg.sv
package status_pkg;

    localparam int REG_W = 8;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_ZTEST = 3'd1,
        OP_ADD   = 3'd2,
        OP_SUB   = 3'd3,
        OP_ROR   = 3'd4,
        OP_ROL   = 3'd5
    } alu_op_e;

    // register layout, MSB first; the packed order is the bit order
    typedef struct packed {
        logic [2:0] page;
        logic       tmo;
        logic       pwd;
        logic       z;
        logic       dc;
        logic       c;
    } stat_t;

    typedef struct packed {
        logic z;
        logic dc;
        logic c;
    } flag_t;

    localparam stat_t STAT_RESET = '{page: 3'b000, tmo: 1'b1, pwd: 1'b1,
                                     z: 1'b0, dc: 1'b0, c: 1'b0};

endpackage

// File: rtl/status_flag_gen.sv
module status_flag_gen
    import status_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output flag_t        fmask,
    output flag_t        fval
);
    localparam int H = W / 2;

    logic [W:0] sum_full;
    logic [H:0] sum_low;
    logic [W:0] dif_full;
    logic [H:0] dif_low;
    alu_op_e    kind;

    always_comb begin
        kind     = alu_op_e'(op);
        sum_full = {1'b0, opa} + {1'b0, opb};
        sum_low  = {1'b0, opa[H-1:0]} + {1'b0, opb[H-1:0]};
        dif_full = {1'b0, opa} - {1'b0, opb};
        dif_low  = {1'b0, opa[H-1:0]} - {1'b0, opb[H-1:0]};
        fmask    = '0;
        fval     = '0;
        case (kind)
            OP_ZTEST: begin
                fmask.z = 1'b1;
                fval.z  = (opa == '0);
            end
            OP_ADD: begin
                fmask   = '{z: 1'b1, dc: 1'b1, c: 1'b1};
                fval.z  = (sum_full[W-1:0] == '0);
                fval.dc = sum_low[H];
                fval.c  = sum_full[W];
            end
            OP_SUB: begin
                fmask   = '{z: 1'b1, dc: 1'b1, c: 1'b1};
                fval.z  = (dif_full[W-1:0] == '0);
                fval.dc = ~dif_low[H];
                fval.c  = ~dif_full[W];
            end
            OP_ROR: begin
                fmask.c = 1'b1;
                fval.c  = opa[0];
            end
            OP_ROL: begin
                fmask.c = 1'b1;
                fval.c  = opa[W-1];
            end
            default: begin
                fmask = '0;
                fval  = '0;
            end
        endcase
    end

endmodule

// File: rtl/status_cause_ctl.sv
module status_cause_ctl (
    input  logic tmo_cur,
    input  logic pwd_cur,
    input  logic ev_clr,
    input  logic ev_sleep,
    input  logic ev_tmo,
    output logic tmo_nxt,
    output logic pwd_nxt
);
    always_comb begin
        // time-out: set events outrank the time-out clear
        if (ev_clr || ev_sleep)
            tmo_nxt = 1'b1;
        else if (ev_tmo)
            tmo_nxt = 1'b0;
        else
            tmo_nxt = tmo_cur;

        // power-down: clear instruction outranks sleep
        if (ev_clr)
            pwd_nxt = 1'b1;
        else if (ev_sleep)
            pwd_nxt = 1'b0;
        else
            pwd_nxt = pwd_cur;
    end
endmodule

// File: rtl/status_reg.sv
module status_reg
    import status_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [2:0]       alu_op,
    input  logic [W-1:0]     alu_a,
    input  logic [W-1:0]     alu_b,
    input  logic             wdt_clr,
    input  logic             sleep_cmd,
    input  logic             wdt_tmo,
    output logic [REG_W-1:0] stat_q,
    output logic [1:0]       page_sel
);
    stat_t st_d, st_q;
    stat_t wr_view;
    flag_t fmask, fval, fcur;
    logic  tmo_n, pwd_n;
    logic  flag_lock;

    status_flag_gen #(.W(W)) u_flags (
        .op    (alu_op),
        .opa   (alu_a),
        .opb   (alu_b),
        .fmask (fmask),
        .fval  (fval)
    );

    status_cause_ctl u_cause (
        .tmo_cur  (st_q.tmo),
        .pwd_cur  (st_q.pwd),
        .ev_clr   (wdt_clr),
        .ev_sleep (sleep_cmd),
        .ev_tmo   (wdt_tmo),
        .tmo_nxt  (tmo_n),
        .pwd_nxt  (pwd_n)
    );

    always_comb begin
        wr_view   = stat_t'(wr_data);
        fcur      = '{z: st_q.z, dc: st_q.dc, c: st_q.c};
        flag_lock = |fmask;
        st_d      = st_q;

        if (wr_en) begin
            st_d.page = wr_view.page;
            if (!flag_lock) begin
                st_d.z  = wr_view.z;
                st_d.dc = wr_view.dc;
                st_d.c  = wr_view.c;
            end
        end

        if (flag_lock) begin
            st_d.z  = fmask.z  ? fval.z  : fcur.z;
            st_d.dc = fmask.dc ? fval.dc : fcur.dc;
            st_d.c  = fmask.c  ? fval.c  : fcur.c;
        end

        st_d.tmo = tmo_n;
        st_d.pwd = pwd_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= STAT_RESET;
        else
            st_q <= st_d;
    end

    assign stat_q   = st_q;
    assign page_sel = st_q.page[1:0];

endmodule

// File: rtl/status_reg_chk.sv
module status_reg_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [7:0]   wr_data,
    input logic [2:0]   alu_op,
    input logic [W-1:0] alu_a,
    input logic [W-1:0] alu_b,
    input logic         wdt_clr,
    input logic         sleep_cmd,
    input logic         wdt_tmo,
    input logic [7:0]   stat_q,
    input logic [1:0]   page_sel
);
    logic no_ev;
    logic no_flag_op;
    assign no_ev      = !wdt_clr && !sleep_cmd && !wdt_tmo;
    assign no_flag_op = (alu_op == 3'd0) || (alu_op > 3'd5);

    // R3
    sw_write_keeps_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && no_ev) |=> $stable(stat_q[4:3]));

    // R9
    clr_sets_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_clr || sleep_cmd) |=> stat_q[4]);

    // R10
    sleep_clears_pwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_cmd && !wdt_clr) |=> !stat_q[3]);

    // R9
    tmo_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_tmo && !wdt_clr && !sleep_cmd) |=> !stat_q[4]);

    // R8
    ror_loads_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 3'd4) |=> (stat_q[0] == $past(alu_a[0])) && $stable(stat_q[2:1]));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && no_flag_op && no_ev) |=> $stable(stat_q));

    // R12
    page_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_sel == stat_q[6:5]);
endmodule

bind status_reg status_reg_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .alu_op    (alu_op),
    .alu_a     (alu_a),
    .alu_b     (alu_b),
    .wdt_clr   (wdt_clr),
    .sleep_cmd (sleep_cmd),
    .wdt_tmo   (wdt_tmo),
    .stat_q    (stat_q),
    .page_sel  (page_sel)
);

// File: tb/sim_status_reg.sv
module sim_status_reg;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] alu_op = '0;
    logic [7:0] alu_a = '0;
    logic [7:0] alu_b = '0;
    logic       wdt_clr = 1'b0;
    logic       sleep_cmd = 1'b0;
    logic       wdt_tmo = 1'b0;
    logic [7:0] stat_q;
    logic [1:0] page_sel;

    int   n_chk = 0;
    int   n_bad = 0;
    logic [7:0] model = 8'h18;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_reg #(.W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b),
        .wdt_clr(wdt_clr), .sleep_cmd(sleep_cmd), .wdt_tmo(wdt_tmo),
        .stat_q(stat_q), .page_sel(page_sel)
    );

    // expected next value, written from the requirements
    function automatic logic [7:0] predict(input logic [7:0] cur, input logic we,
        input logic [7:0] d, input logic [2:0] op, input logic [7:0] a,
        input logic [7:0] b, input logic clr, input logic slp, input logic tmo);
        logic [7:0] n;
        logic [8:0] s;
        logic [4:0] sl;
        n = cur;
        s = '0;
        sl = '0;
        if (we) n[7:5] = d[7:5];
        if (we && (op == 3'd0 || op > 3'd5)) n[2:0] = d[2:0];
        case (op)
            3'd1: n[2] = (a == 8'h00);
            3'd2: begin
                s = {1'b0, a} + {1'b0, b};
                sl = {1'b0, a[3:0]} + {1'b0, b[3:0]};
                n[2] = (s[7:0] == 8'h00); n[1] = sl[4]; n[0] = s[8];
            end
            3'd3: begin
                n[2] = (a == b); n[1] = (a[3:0] >= b[3:0]); n[0] = (a >= b);
            end
            3'd4: n[0] = a[0];
            3'd5: n[0] = a[7];
            default: ;
        endcase
        if (clr || slp) n[4] = 1'b1; else if (tmo) n[4] = 1'b0;
        if (clr) n[3] = 1'b1; else if (slp) n[3] = 1'b0;
        return n;
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        n_chk++;
        if (stat_q !== exp || page_sel !== exp[6:5]) begin
            n_bad++;
            $display("FAIL %s: stat_q=%02h page_sel=%0d expected %02h page_sel=%0d",
                     req, stat_q, page_sel, exp, exp[6:5]);
        end
    endtask

    // drive at negedge, let one edge pass, sample a quarter period later
    task automatic cyc(input string req, input logic we, input logic [7:0] d,
        input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
        input logic clr, input logic slp, input logic tmo);
        @(negedge clk);
        wr_en = we; wr_data = d; alu_op = op; alu_a = a; alu_b = b;
        wdt_clr = clr; sleep_cmd = slp; wdt_tmo = tmo;
        model = predict(model, we, d, op, a, b, clr, slp, tmo);
        @(posedge clk);
        #(CLK_PERIOD/4);
        check(req, model);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset value", 8'h18);
        rst_n = 1'b1;

        // R2 plain write; R3 cause bits untouched by data
        cyc("R2 plain write", 1, 8'hE7, 3'd0, 8'h00, 8'h00, 0, 0, 0);
        check("R3 write keeps tmo/pwd", 8'hFF);
        cyc("R3 write zero", 1, 8'h00, 3'd7, 8'h00, 8'h00, 0, 0, 0);
        cyc("R2 reload", 1, 8'hE7, 3'd6, 8'h00, 8'h00, 0, 0, 0);
        // R4 clear example: page 000, Z=1, DC/C kept
        cyc("R4 clear example", 1, 8'h00, 3'd1, 8'h00, 8'h00, 0, 0, 0);
        check("R4 clear value", 8'h1F);
        // R5 zero test, non-zero operand, no write
        cyc("R5 zero test nonzero", 0, 8'h00, 3'd1, 8'h40, 8'h00, 0, 0, 0);
        // R6 add corners
        cyc("R6 add nibble carry", 0, 8'h00, 3'd2, 8'h0F, 8'h01, 0, 0, 0);
        check("R6 add 0F+01", 8'h1A);
        cyc("R6 add wrap", 1, 8'hA0, 3'd2, 8'hFF, 8'h01, 0, 0, 0);
        check("R6 add FF+01 with write", 8'hBF);
        // R7 subtract corners
        cyc("R7 sub equal", 0, 8'h00, 3'd3, 8'h05, 8'h05, 0, 0, 0);
        cyc("R7 sub borrow", 0, 8'h00, 3'd3, 8'h03, 8'h04, 0, 0, 0);
        check("R7 sub 03-04", 8'hB8);
        // R8 rotates
        cyc("R8 ror lsb", 0, 8'h00, 3'd4, 8'h01, 8'h00, 0, 0, 0);
        cyc("R8 rol msb", 0, 8'h00, 3'd5, 8'h7F, 8'h00, 0, 0, 0);
        cyc("R8 rol msb set", 0, 8'h00, 3'd5, 8'h80, 8'h00, 0, 0, 0);
        // R9 / R10 events and priorities
        cyc("R9 timeout", 0, 8'h00, 3'd0, 8'h00, 8'h00, 0, 0, 1);
        cyc("R10 sleep", 0, 8'h00, 3'd0, 8'h00, 8'h00, 0, 1, 0);
        cyc("R9 R10 clr beats tmo", 0, 8'h00, 3'd0, 8'h00, 8'h00, 1, 0, 1);
        cyc("R9 sleep beats tmo", 0, 8'h00, 3'd0, 8'h00, 8'h00, 0, 1, 1);
        cyc("R10 clr beats sleep", 0, 8'h00, 3'd0, 8'h00, 8'h00, 1, 1, 0);
        cyc("R3 write during tmo", 1, 8'h18, 3'd0, 8'h00, 8'h00, 0, 0, 1);
        // R11 idle hold
        cyc("R11 idle", 0, 8'hFF, 3'd6, 8'hFF, 8'hFF, 0, 0, 0);
        cyc("R11 idle again", 0, 8'h55, 3'd0, 8'h00, 8'h00, 0, 0, 0);

        for (int i = 0; i < N_RAND; i++) begin
            logic [2:0] ev;
            ev = 3'($urandom_range(0, 7));
            cyc("R2-R12 random", 1'($urandom_range(0, 1)), 8'($urandom),
                3'($urandom), 8'($urandom), 8'($urandom),
                ev == 3'd1 || ev == 3'd4, ev == 3'd2 || ev == 3'd4,
                ev == 3'd3 || ev == 3'd5);
        end

        // R1 reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #(CLK_PERIOD/4);
        model = 8'h18;
        check("R1 async reset", 8'h18);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule